// File: doc/BRIEF.md
# Software Inter-Processor Interrupt Controller

This block lets any hart in a cluster of up to 32 raise a machine-software interrupt on any hart, itself included. Software reaches it through a plain 32-bit word-addressed read/write port and receives one software-interrupt line per hart. Each hart owns one source: source ID h+1 is reserved for hart h, and ID 0 does not exist. A source has a priority word, a pending bit that software sets, and an enable bit in each hart's enable words.

To signal hart h, software writes a single 1 into the pending bit of ID h+1. The target hart sees its line rise. It then reads its claim register. That read returns the best source that is pending, enabled for it and not already in service, clears the pending bit, and marks the source in service. The hart finishes by writing the same ID back to the claim register, which takes the source out of service.

Read data is combinational in the cycle of the request. Every state change, the side effects of a claim included, takes effect at the next clock edge.

Top module: `swint_ctrl`

## Requirements
- R1: Pending word w sits at byte offset 0x1000 + 4*w and holds IDs 32*w to 32*w+31, with ID n at bit n%32. A write sets each bit written as 1 and leaves every other pending bit unchanged. A write whose data is all zeros changes nothing.
- R2: Bit 0 of pending word 0 and bit 0 of every hart's enable word 0 belong to ID 0. These bits, and the bits of IDs above the hart count, always read 0 and ignore writes.
- R3: The enable words for hart h sit at 0x2000 + 0x80*h + 4*w and use the same ID-to-bit packing as pending. They are plain read/write registers.
- R4: The priority of ID n sits at 0x4 + 4*(n-1). It keeps the low PRIO_W bits of the written data and reads back zero-extended.
- R5: The interrupt line of hart h is high exactly when some source is pending, enabled for h, not in service and has non-zero priority.
- R6: A read of hart h's claim register at 0x200000 + 0x1000*h + 0x4 returns the ID of the highest-priority source that is eligible under R5, or 0 if there is none. When priorities are equal, the lowest ID wins.
- R7: A claim that returns a non-zero ID clears that ID's pending bit and marks the source in service. While it is in service, the source is never presented to any hart, even after it is set pending again.
- R8: A write of ID n to hart h's claim register takes n out of service only if n is in service and enabled for h. Any other completion write has no effect.
- R9: A read of any other offset, a misaligned offset included, returns 0, and a write to such an offset changes nothing.
- R10: While the synchronous active-high reset is sampled high, all pending, enable, in-service and priority state clears to zero, and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A register access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the cycle of a read request |
| msip | output | NUM_HARTS | Software-interrupt line per hart |

## Verification
The assertions assume that each access lasts one cycle, that the write flag is stable while valid is high, and that reset is held for at least two edges before its first release. The bench drives every access from a task that raises valid for exactly one clock and lowers it before the next access. It samples read data after the inputs settle, before the edge that commits the access. The properties on in-service and pending bits also assume that only claim-region traffic lowers those bits. The stimulus never relies on any other way to lower them.

// File: rtl/swint_pkg.sv
`timescale 1ns/1ps
package swint_pkg;

    localparam logic [31:0] PRIO_BASE  = 32'h0000_0004;
    localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
    localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
    localparam logic [31:0] CLAIM_OFS  = 32'h0000_0004;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_CLAIM
    } region_e;

    typedef struct packed {
        region_e    rg;
        logic [5:0] hart;
        logic [5:0] word;
        logic [5:0] src;
    } decode_t;

endpackage

// File: rtl/swint_decode.sv
`timescale 1ns/1ps
module swint_decode
    import swint_pkg::*;
#(
    parameter int NUM_HARTS = 32,
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 22
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    localparam logic [31:0] PRIO_END = PRIO_BASE + 32'(4 * NUM_HARTS);
    localparam logic [31:0] PEND_END = PEND_BASE + 32'(4 * NUM_WORDS);
    localparam logic [31:0] EN_END   = EN_BASE + EN_STRIDE * 32'(NUM_HARTS);
    localparam logic [31:0] CTX_END  = CTX_BASE + CTX_STRIDE * 32'(NUM_HARTS);

    logic [31:0] a;
    logic [31:0] off;

    always_comb begin
        a   = 32'(addr);
        off = '0;
        dec = '{rg: RG_NONE, hart: '0, word: '0, src: '0};
        if (a[1:0] == 2'b00) begin
            if (a >= PRIO_BASE && a < PRIO_END) begin
                off     = a - PRIO_BASE;
                dec.rg  = RG_PRIO;
                dec.src = 6'(off >> 2);
            end else if (a >= PEND_BASE && a < PEND_END) begin
                off      = a - PEND_BASE;
                dec.rg   = RG_PEND;
                dec.word = 6'(off >> 2);
            end else if (a >= EN_BASE && a < EN_END) begin
                off      = a - EN_BASE;
                dec.hart = 6'(off >> 7);
                dec.word = 6'((off & 32'h7f) >> 2);
                if ((off & 32'h7f) < 32'(4 * NUM_WORDS))
                    dec.rg = RG_EN;
            end else if (a >= CTX_BASE && a < CTX_END) begin
                off      = a - CTX_BASE;
                dec.hart = 6'(off >> 12);
                if ((off & 32'hfff) == CLAIM_OFS)
                    dec.rg = RG_CLAIM;
            end
        end
    end
endmodule

// File: rtl/swint_pick.sv
`timescale 1ns/1ps
module swint_pick #(
    parameter int NUM_IDS = 33,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 6
) (
    input  logic [NUM_IDS-1:0] cand,
    input  logic [PRIO_W-1:0]  prio [NUM_IDS],
    output logic [ID_W-1:0]    win_id,
    output logic               win_any
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        win_id = '0;
        best_p = '0;
        // strict compare: zero priority never wins, lowest ID keeps ties
        for (int i = 1; i < NUM_IDS; i++) begin
            if (cand[i] && prio[i] > best_p) begin
                best_p = prio[i];
                win_id = ID_W'(i);
            end
        end
        win_any = (win_id != '0);
    end
endmodule

// File: rtl/swint_ctrl.sv
`timescale 1ns/1ps
module swint_ctrl
    import swint_pkg::*;
#(
    parameter int NUM_HARTS = 32,
    parameter int PRIO_W    = 3,
    parameter int ADDR_W    = 22
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    output logic [31:0]          rd_data,
    output logic [NUM_HARTS-1:0] msip
);
    localparam int NUM_IDS   = NUM_HARTS + 1;
    localparam int NUM_WORDS = (NUM_IDS + 31) / 32;
    localparam int PAD_W     = 32 * NUM_WORDS;
    localparam int ID_W      = $clog2(NUM_IDS);
    localparam int HIDX_W    = $clog2(NUM_HARTS);
    localparam logic [NUM_IDS-1:0] ID_OK = {{NUM_HARTS{1'b1}}, 1'b0};

    typedef struct {
        logic [NUM_IDS-1:0] pend;
        logic [NUM_IDS-1:0] insvc;
        logic [NUM_IDS-1:0] en   [NUM_HARTS];
        logic [PRIO_W-1:0]  prio [NUM_IDS];
    } state_t;

    state_t s_q, s_d;

    decode_t           dec;
    logic [ID_W-1:0]   win_id  [NUM_HARTS];
    logic              win_any [NUM_HARTS];
    logic [HIDX_W-1:0] hsel;
    logic [ID_W-1:0]   wr_id;
    logic [PAD_W-1:0]  pad_rd, pad_wr, pad_mask;
    logic              rd_go, wr_go;

    swint_decode #(.NUM_HARTS(NUM_HARTS), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic [NUM_IDS-1:0] cand;
        assign cand = s_q.pend & s_q.en[h] & ~s_q.insvc;
        swint_pick #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
            .cand    (cand),
            .prio    (s_q.prio),
            .win_id  (win_id[h]),
            .win_any (win_any[h])
        );
        assign msip[h] = win_any[h];

        a_r2_en_id0_zero: assert property (@(posedge clk) disable iff (rst)
            s_q.en[h][0] == 1'b0 && (s_q.en[h] & ~ID_OK) == '0);
        a_r5_line_needs_source: assert property (@(posedge clk) disable iff (rst)
            msip[h] |-> (s_q.pend & s_q.en[h] & ~s_q.insvc) != '0);
    end

    always_comb begin
        s_d      = s_q;
        rd_data  = '0;
        rd_go    = req_valid && !req_write;
        wr_go    = req_valid && req_write;
        hsel     = dec.hart[HIDX_W-1:0];
        wr_id    = req_wdata[ID_W-1:0];
        pad_rd   = '0;
        pad_wr   = '0;
        pad_mask = '0;
        pad_wr[int'(dec.word)*32 +: 32]   = req_wdata;
        pad_mask[int'(dec.word)*32 +: 32] = '1;

        unique case (dec.rg)
            RG_PRIO: begin
                if (rd_go)
                    rd_data = 32'(s_q.prio[ID_W'(dec.src) + ID_W'(1)]);
                if (wr_go)
                    s_d.prio[ID_W'(dec.src) + ID_W'(1)] = req_wdata[PRIO_W-1:0];
            end
            RG_PEND: begin
                pad_rd[NUM_IDS-1:0] = s_q.pend;
                if (rd_go)
                    rd_data = pad_rd[int'(dec.word)*32 +: 32];
                if (wr_go)
                    s_d.pend = s_q.pend | (pad_wr[NUM_IDS-1:0] & ID_OK);
            end
            RG_EN: begin
                pad_rd[NUM_IDS-1:0] = s_q.en[hsel];
                if (rd_go)
                    rd_data = pad_rd[int'(dec.word)*32 +: 32];
                if (wr_go)
                    s_d.en[hsel] = (s_q.en[hsel] & ~pad_mask[NUM_IDS-1:0])
                                 | (pad_wr[NUM_IDS-1:0] & ID_OK);
            end
            RG_CLAIM: begin
                if (rd_go) begin
                    rd_data = 32'(win_id[hsel]);
                    if (win_id[hsel] != '0) begin
                        s_d.pend[win_id[hsel]]  = 1'b0;
                        s_d.insvc[win_id[hsel]] = 1'b1;
                    end
                end
                if (wr_go && req_wdata != '0 && req_wdata < 32'(NUM_IDS)
                    && s_q.en[hsel][wr_id] && s_q.insvc[wr_id])
                    s_d.insvc[wr_id] = 1'b0;
            end
            default: ;
        endcase

        s_d.prio[0] = '0;
        if (rst) begin
            s_d.pend  = '0;
            s_d.insvc = '0;
            for (int h = 0; h < NUM_HARTS; h++) s_d.en[h] = '0;
            for (int i = 0; i < NUM_IDS; i++) s_d.prio[i] = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // R10: reset clears pending and lines
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (s_q.pend == '0 && s_q.insvc == '0 && msip == '0));

    // R2: ID 0 never pending nor in service
    a_r2_id0_pend_zero: assert property (@(posedge clk) disable iff (rst)
        s_q.pend[0] == 1'b0 && s_q.insvc[0] == 1'b0);

    // R6: an idle hart's claim reads zero
    a_r6_idle_claim_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_go && dec.rg == RG_CLAIM && !msip[hsel]) |-> rd_data == '0);

    // R7: a claimed ID is in service and no longer pending
    a_r7_claim_marks: assert property (@(posedge clk) disable iff (rst)
        (rd_go && dec.rg == RG_CLAIM && rd_data != '0)
        |=> (s_q.insvc[$past(rd_data[ID_W-1:0])] && !s_q.pend[$past(rd_data[ID_W-1:0])]));

    // R1: pending bits drop only through a claim read
    a_r1_pend_no_clear: assert property (@(posedge clk) disable iff (rst)
        !(rd_go && dec.rg == RG_CLAIM) |=> ((~s_q.pend & $past(s_q.pend)) == '0));

    // R8: service bits drop only through a claim-register write
    a_r8_insvc_drop_on_write: assert property (@(posedge clk) disable iff (rst)
        !(wr_go && dec.rg == RG_CLAIM) |=> ((~s_q.insvc & $past(s_q.insvc)) == '0));

endmodule

// File: tb/sim_swint_ctrl.sv
`timescale 1ns/1ps
module sim_swint_ctrl;
    localparam int NH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [NH-1:0] msip;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    bit [NH:0] m_pend, m_insvc;
    bit [NH:0] m_en [NH];
    int        m_prio [NH+1];

    always #2.5 clk = ~clk;

    swint_ctrl #(.NUM_HARTS(NH), .PRIO_W(3), .ADDR_W(22)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .msip(msip)
    );

    function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    function automatic int m_pick(int h);
        int best = 0;
        int bp = 0;
        for (int id = 1; id <= NH; id++)
            if (m_pend[id] && m_en[h][id] && !m_insvc[id] && m_prio[id] > bp) begin
                bp = m_prio[id];
                best = id;
            end
        return best;
    endfunction

    function automatic logic [31:0] m_msip();
        logic [31:0] v = '0;
        for (int h = 0; h < NH; h++) v[h] = (m_pick(h) != 0);
        return v;
    endfunction

    function automatic logic [31:0] m_word(bit [NH:0] v, int w);
        logic [63:0] p = '0;
        p[NH:0] = v;
        return p[w*32 +: 32];
    endfunction

    task automatic bus_wr(int addr, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = 22'(addr); req_wdata = d;
        @(posedge clk);
        #1 req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(int addr, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 22'(addr);
        #1 d = rd_data;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic rd_chk(string tag, int addr, logic [31:0] exp);
        logic [31:0] d;
        bus_rd(addr, d);
        chk(tag, d, exp);
    endtask

    task automatic msip_chk(string tag);
        @(negedge clk);
        #1 chk(tag, 32'(msip), m_msip());
    endtask

    task automatic set_prio(int id, logic [31:0] d);
        bus_wr(4 + 4*(id-1), d);
        m_prio[id] = int'(d[2:0]);
    endtask

    task automatic set_pend(int w, logic [31:0] d);
        bus_wr(32'h1000 + 4*w, d);
        for (int b = 0; b < 32; b++)
            if (d[b] && w*32+b >= 1 && w*32+b <= NH) m_pend[w*32+b] = 1'b1;
    endtask

    task automatic set_en(int h, int w, logic [31:0] d);
        bus_wr(32'h2000 + 32'h80*h + 4*w, d);
        for (int b = 0; b < 32; b++)
            if (w*32+b <= NH) m_en[h][w*32+b] = (w*32+b >= 1) ? d[b] : 1'b0;
    endtask

    task automatic do_claim(string tag, int h);
        int exp = m_pick(h);
        rd_chk(tag, 32'h200000 + 32'h1000*h + 4, 32'(exp));
        if (exp != 0) begin
            m_pend[exp] = 1'b0;
            m_insvc[exp] = 1'b1;
        end
    endtask

    task automatic complete(int h, int id);
        bus_wr(32'h200000 + 32'h1000*h + 4, 32'(id));
        if (id >= 1 && id <= NH && m_en[h][id] && m_insvc[id]) m_insvc[id] = 1'b0;
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        m_pend = '0; m_insvc = '0;
        for (int h = 0; h < NH; h++) m_en[h] = '0;
        for (int i = 0; i <= NH; i++) m_prio[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10: reset state
        msip_chk("R10 lines after reset");
        rd_chk("R10 pending word0", 32'h1000, 0);
        rd_chk("R10 pending word1", 32'h1004, 0);
        rd_chk("R10 claim idle", 32'h200004, 0);
        rd_chk("R10 priority", 32'h4, 0);

        // R4: priority sweep with upper-bit noise
        for (int id = 1; id <= NH; id++)
            set_prio(id, 32'hFFFF_FFF8 | 32'((id*5) % 7 + 1));
        for (int id = 1; id <= NH; id++)
            rd_chk("R4 priority readback", 4 + 4*(id-1), 32'((id*5) % 7 + 1));

        // R3 / R2: enable all, then one-per-hart
        for (int h = 0; h < NH; h++) begin
            set_en(h, 0, 32'hFFFF_FFFF);
            set_en(h, 1, 32'hFFFF_FFFF);
            rd_chk("R2 enable word0 id0 bit", 32'h2000 + 32'h80*h, 32'hFFFF_FFFE);
            rd_chk("R2 enable word1 high ids", 32'h2004 + 32'h80*h, 32'h1);
            set_en(h, 0, (h + 1 < 32) ? (32'h1 << (h + 1)) : 32'h0);
            set_en(h, 1, (h == 31) ? 32'h1 : 32'h0);
            rd_chk("R3 enable word0", 32'h2000 + 32'h80*h, m_word(m_en[h], 0));
            rd_chk("R3 enable word1", 32'h2004 + 32'h80*h, m_word(m_en[h], 1));
        end

        // R5 / R6 / R7 / R8: self and cross IPI sweep over every hart
        for (int x = 0; x < NH; x++) begin
            set_pend((x + 1) / 32, 32'h1 << ((x + 1) % 32));
            msip_chk("R5 line for target");
            do_claim("R6 claim own id", x);
            msip_chk("R7 line drops after claim");
            rd_chk("R7 pending cleared", 32'h1000 + 4*((x + 1) / 32), 0);
            complete(x, x + 1);
            msip_chk("R8 line stays low after completion");
        end

        // R1: set semantics
        set_pend(0, 32'h4);
        set_pend(0, 32'h20);
        rd_chk("R1 both bits kept", 32'h1000, 32'h24);
        set_pend(0, 32'h0);
        rd_chk("R1 zero write no effect", 32'h1000, 32'h24);
        msip_chk("R5 two targets");
        do_claim("R6 hart1 claim", 1);
        do_claim("R6 hart4 claim", 4);
        complete(1, 2);
        complete(4, 5);

        // R2: ID 0 write ignored
        set_pend(0, 32'h1);
        rd_chk("R2 pending id0", 32'h1000, 0);
        msip_chk("R2 no line from id0");

        // R6: priority order and ties on hart 0
        set_en(0, 0, 32'h1FE);
        set_pend(0, 32'h1FE);
        for (int k = 0; k < 9; k++) begin
            msip_chk("R5 lines during drain");
            do_claim("R6 priority order", 0);
        end
        for (int id = 1; id <= 8; id++) complete(0, id);
        msip_chk("R8 all completed");

        // R5: zero priority masks a source
        set_prio(3, 0);
        set_pend(0, 32'h8);
        msip_chk("R5 zero priority no line");
        do_claim("R5 zero priority no claim", 2);
        set_prio(3, 2);
        msip_chk("R5 nonzero priority line");
        do_claim("R6 hart2 claims", 2);
        set_pend(0, 32'h8);
        msip_chk("R7 in service not presented");
        rd_chk("R7 repend visible", 32'h1000, 32'h8);
        do_claim("R7 in service claim zero", 0);
        complete(2, 4);
        msip_chk("R8 wrong id ignored");
        complete(5, 3);
        msip_chk("R8 non-enabled hart ignored");
        complete(0, 3);
        msip_chk("R8 matching completion reopens");
        do_claim("R8 hart0 reclaims", 0);
        complete(0, 3);
        msip_chk("R8 final state");

        // R9: unmapped offsets
        rd_chk("R9 offset 0", 32'h0, 0);
        rd_chk("R9 pending word2", 32'h1008, 0);
        rd_chk("R9 enable word2", 32'h2008, 0);
        rd_chk("R9 enable past harts", 32'h3000, 0);
        rd_chk("R9 context offset 0", 32'h200000, 0);
        rd_chk("R9 context past harts", 32'h220004, 0);
        rd_chk("R9 misaligned", 32'h1001, 0);
        rd_chk("R9 priority past sources", 32'h84, 0);
        bus_wr(32'h1008, 32'hFFFF_FFFF);
        bus_wr(32'h1001, 32'hFFFF_FFFF);
        bus_wr(32'h1002, 32'hFFFF_FFFF);
        bus_wr(32'h3000, 32'hFFFF_FFFF);
        bus_wr(32'h0, 32'hFFFF_FFFF);
        rd_chk("R9 pending word0 untouched", 32'h1000, m_word(m_pend, 0));
        rd_chk("R9 pending word1 untouched", 32'h1004, m_word(m_pend, 1));
        rd_chk("R9 priority 1 untouched", 32'h4, 32'(m_prio[1]));
        msip_chk("R9 lines untouched");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule